// File: doc/BRIEF.md
# Probe Snapshot Query Responder

This block sits behind a byte-wide host link and answers a short poll with the state of every probe input. The host sends a fixed opcode byte and then a count byte. The block replies with one byte per probe, starting at probe 0 and counting up. Each reply byte carries the probe's position, its current level, and two sticky flags. The flags record whether the probe rose or fell at any point since that probe was last reported.

The probe inputs pass through a two-flop stage before any edge detection. The number of probes is the parameter `NPROBE`, normally 8 or 18, and it sets where the index sits inside the reply byte. The receive side has no ready signal, so every byte presented with `rx_valid` is taken. The transmit side is a valid/ready stream. A byte moves on any rising edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the offered byte is held unchanged. The stream never withdraws a byte it has offered.

Top module: `probe_snap_responder`

## Requirements
- R1: A query is the byte 0x19 followed by a byte with bit 7 set. Bits 6..0 of the second byte are the requested count. A reply starts only after such a pair.
- R2: The reply holds min(requested count, NPROBE) bytes, one per probe, in ascending probe order from probe 0. A count of zero produces no bytes.
- R3: Layout of each reply byte:
  - bit 0 is the synchronized probe level (1 = high).
  - bit 1 is the rising flag.
  - bit 2 is the falling flag.
  - With more than 8 probes, the probe index is shifted left by 3. With 8 or fewer probes, it is shifted left by 4.
- R4: The flags are sticky. Any rise or fall seen since the probe's previous report sets the matching flag. A short pulse between two polls sets both flags.
- R5: A probe's flags are cleared when its byte is captured for sending. A probe that holds its level until the next poll then reports both flags as 0. In the 8-probe build, probe 1 reads 0x13 after rising and 0x11 on the following poll.
- R6: An edge detected in the same cycle that a probe's byte is captured goes into that byte. It is not reported a second time.
- R7: A first byte other than 0x19 is discarded. A second byte with bit 7 clear discards the query. In both cases the parser goes back to waiting for 0x19.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R9: A query that completes while a reply is still in progress is dropped.
- R10: After reset, `tx_valid` is low, all flags are clear and all levels are taken as low.
- R11: The first reply byte is offered on the cycle after the edge that accepts the count byte. With `tx_ready` held high, the bytes follow on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_data | input | 8 | Host byte in |
| rx_valid | input | 1 | rx_data is valid this cycle |
| probes_in | input | NPROBE | Probe levels, one bit per probe |
| tx_data | output | 8 | Reply byte out |
| tx_valid | output | 1 | tx_data is offered |
| tx_ready | input | 1 | Sink accepts tx_data this cycle |

## Verification
Two things can land in the same clock cycle: a probe edge being detected, and the capture of that probe's reply byte, which also clears its flags. The bench provokes this by stalling a reply with `tx_ready` low. It schedules a rise on probe 1 so that the edge reaches the detector on the exact edge where the release of `tx_ready` loads probe 1's byte. It then checks two things. The captured byte must carry both the rising flag and the high level. The next poll must show the level with no flag, so the edge is neither lost nor reported twice.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam logic [7:0] QUERY_OPCODE = 8'h19;

  typedef enum logic {
    PS_OPCODE,
    PS_COUNT
  } psr_state_e;

  function automatic int idx_shift(input int nprobe);
    return (nprobe > 8) ? 3 : 4;
  endfunction

  function automatic logic [7:0] pack_byte(input logic [7:0] idx, input int sh,
                                           input logic fall, input logic rise,
                                           input logic lvl);
    logic [7:0] b;
    b = (idx << sh) | {5'b0, fall, rise, lvl};
    return b;
  endfunction

endpackage

// File: rtl/psr_sync2.sv
module psr_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_in;
      stage2 <= stage1;
    end
  end

  assign d_out = stage2;
endmodule

// File: rtl/psr_edge_tracker.sv
module psr_edge_tracker #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] clr,
  output logic [W-1:0] rep_rise,
  output logic [W-1:0] rep_fall
);
  logic [W-1:0] prev_lvl;
  logic [W-1:0] rise_now;
  logic [W-1:0] fall_now;
  logic [W-1:0] rflag;
  logic [W-1:0] fflag;

  assign rise_now = lvl & ~prev_lvl;
  assign fall_now = ~lvl & prev_lvl;

  // reported value includes an edge seen in the capture cycle itself
  assign rep_rise = rflag | rise_now;
  assign rep_fall = fflag | fall_now;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_lvl[i] <= 1'b0;
          rflag[i]    <= 1'b0;
          fflag[i]    <= 1'b0;
        end else begin
          prev_lvl[i] <= lvl[i];
          rflag[i]    <= clr[i] ? 1'b0 : (rflag[i] | rise_now[i]);
          fflag[i]    <= clr[i] ? 1'b0 : (fflag[i] | fall_now[i]);
        end
      end

      // R4: a set flag survives until its probe is reported
      p_rise_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rflag[i] && !clr[i]) |=> rflag[i]);
      p_fall_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fflag[i] && !clr[i]) |=> fflag[i]);
      // R5/R6: capture empties the flags, nothing is carried over
      p_clear_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr[i] |=> !rflag[i]);
      p_clear_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr[i] |=> !fflag[i]);
    end
  endgenerate

  p_one_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
endmodule

// File: rtl/psr_cmd_parser.sv
module psr_cmd_parser #(
  parameter int NPROBE = 18,
  parameter int IW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rx_data,
  input  logic          rx_valid,
  output logic          start,
  output logic [IW-1:0] start_cnt
);
  import psr_pkg::*;

  psr_state_e st;
  logic [6:0] req;

  assign req       = rx_data[6:0];
  assign start     = rx_valid && (st == PS_COUNT) && rx_data[7];
  assign start_cnt = (int'(req) > NPROBE) ? IW'(NPROBE) : IW'(req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= PS_OPCODE;
    end else if (rx_valid) begin
      case (st)
        PS_OPCODE: if (rx_data == QUERY_OPCODE) st <= PS_COUNT;
        default:   st <= PS_OPCODE;
      endcase
    end
  end

  // R7: bad count byte sends the parser back to opcode hunting
  p_bad_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_COUNT && rx_valid && !rx_data[7]) |=> (st == PS_OPCODE));
  // R1: only the opcode advances the parser
  p_opcode_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_OPCODE && rx_valid && rx_data != QUERY_OPCODE) |=> (st == PS_OPCODE));
endmodule

// File: rtl/psr_tx_serializer.sv
module psr_tx_serializer #(
  parameter int NPROBE = 18,
  parameter int IW     = 5,
  parameter int SHIFT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IW-1:0]     start_cnt,
  input  logic [NPROBE-1:0] lvl,
  input  logic [NPROBE-1:0] rep_rise,
  input  logic [NPROBE-1:0] rep_fall,
  output logic [NPROBE-1:0] clr,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);
  logic          busy;
  logic [IW-1:0] nxt;
  logic [IW-1:0] cnt;
  logic          can_load;
  logic          sel_l, sel_r, sel_f;
  logic [7:0]    next_byte;

  assign can_load = busy && (nxt != cnt) && (!tx_valid || tx_ready);

  always_comb begin
    sel_l = 1'b0;
    sel_r = 1'b0;
    sel_f = 1'b0;
    for (int i = 0; i < NPROBE; i++) begin
      if (nxt == IW'(i)) begin
        sel_l = lvl[i];
        sel_r = rep_rise[i];
        sel_f = rep_fall[i];
      end
    end
    next_byte = psr_pkg::pack_byte(8'(nxt), SHIFT, sel_f, sel_r, sel_l);
  end

  generate
    for (genvar i = 0; i < NPROBE; i++) begin : g_clr
      assign clr[i] = can_load && (nxt == IW'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      nxt      <= '0;
      cnt      <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (!busy) begin
        nxt <= '0;
        if (start) begin
          cnt  <= start_cnt;
          busy <= (start_cnt != '0);
        end
      end else begin
        if (can_load) nxt <= nxt + 1'b1;
        if (nxt == cnt && (!tx_valid || tx_ready)) busy <= 1'b0;
      end
      if (can_load) begin
        tx_valid <= 1'b1;
        tx_data  <= next_byte;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
    end
  end

  // R8: offered byte is held under back-pressure
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R2: count never exceeds the probe count
  p_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cnt) <= NPROBE && nxt <= cnt));
  // R9: a query during a reply does not disturb it
  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cnt));
  // R11: nothing is offered when no reply is running
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid);
endmodule

// File: rtl/probe_snap_responder.sv
module probe_snap_responder #(
  parameter int NPROBE = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic [NPROBE-1:0] probes_in,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);
  localparam int IW    = $clog2(NPROBE + 1);
  localparam int SHIFT = psr_pkg::idx_shift(NPROBE);

  logic [NPROBE-1:0] lvl;
  logic [NPROBE-1:0] rep_rise;
  logic [NPROBE-1:0] rep_fall;
  logic [NPROBE-1:0] clr;
  logic              start;
  logic [IW-1:0]     start_cnt;

  psr_sync2 #(.W(NPROBE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(probes_in), .d_out(lvl)
  );

  psr_edge_tracker #(.W(NPROBE)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .clr(clr),
    .rep_rise(rep_rise), .rep_fall(rep_fall)
  );

  psr_cmd_parser #(.NPROBE(NPROBE), .IW(IW)) u_parse (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .start(start), .start_cnt(start_cnt)
  );

  psr_tx_serializer #(.NPROBE(NPROBE), .IW(IW), .SHIFT(SHIFT)) u_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cnt(start_cnt),
    .lvl(lvl), .rep_rise(rep_rise), .rep_fall(rep_fall), .clr(clr),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  // R10: no byte offered straight out of reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> !tx_valid);
endmodule

// File: tb/sim_probe_snap_responder.sv
module sim_probe_snap_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_valid = 1'b0;
  logic        tx_ready = 1'b1;
  logic [17:0] p18 = '0;
  logic [7:0]  p8 = '0;
  logic [7:0]  d0, d1;
  logic        v0, v1;

  always #2.5 clk = ~clk;

  probe_snap_responder #(.NPROBE(18)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .probes_in(p18), .tx_data(d0), .tx_valid(v0), .tx_ready(tx_ready)
  );
  probe_snap_responder #(.NPROBE(8)) u1 (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .probes_in(p8), .tx_data(d1), .tx_valid(v1), .tx_ready(tx_ready)
  );

  int nchk = 0, nfail = 0, n0 = 0, n1 = 0, hold_bad = 0;
  bit done = 0;
  logic [7:0] got0 [0:31];
  logic [7:0] got1 [0:31];
  logic pend0 = 0, pend1 = 0;
  logic [7:0] pd0, pd1;

  // {p18, p8, expected byte of probe 1 in the 8-probe build}
  localparam logic [33:0] VEC [0:7] = '{
    {18'h00000, 8'h00, 8'h10},
    {18'h00002, 8'h02, 8'h13},
    {18'h00002, 8'h02, 8'h11},
    {18'h00000, 8'h00, 8'h14},
    {18'h00000, 8'h00, 8'h10},
    {18'h2A5C3, 8'hA5, 8'h10},
    {18'h15A3C, 8'h5A, 8'h13},
    {18'h3FFFF, 8'hFF, 8'h11}
  };

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend0 && !(v0 && d0 == pd0)) hold_bad++;
      if (pend1 && !(v1 && d1 == pd1)) hold_bad++;
      pend0 = v0 && !tx_ready; pd0 = d0;
      pend1 = v1 && !tx_ready; pd1 = d1;
      if (v0 && tx_ready) begin if (n0 < 32) got0[n0] = d0; n0++; end
      if (v1 && tx_ready) begin if (n1 < 32) got1[n1] = d1; n1++; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] eb(input int idx, input int sh, input bit f,
                                    input bit r, input bit l);
    return 8'((idx << sh) | (int'(f) << 2) | (int'(r) << 1) | int'(l));
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1; tick(); rx_valid = 1'b0;
  endtask

  task automatic query(input logic [7:0] len);
    send(8'h19); send(len);
  endtask

  task automatic poll(input logic [7:0] len);
    n0 = 0; n1 = 0; tx_ready = 1'b1;
    query(len);
    repeat (30) tick();
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      finish_run();
    end
  end

  initial begin
    logic [17:0] prev18;
    logic [7:0]  prev8;
    repeat (4) tick();
    rst_n = 1'b1;
    @(negedge clk);
    chk(!v0 && !v1, "R10 tx_valid after reset", int'({v0, v1}), 0);
    tick();

    // table walk: R1 R2 R3 R4 R5 R10
    prev18 = '0; prev8 = '0;
    for (int k = 0; k < 8; k++) begin
      p18 = VEC[k][33:16]; p8 = VEC[k][15:8];
      repeat (5) tick();
      poll(8'h92);
      chk(n0 == 18, "R2 count 18-build", n0, 18);
      chk(n1 == 8, "R2 clamp 8-build", n1, 8);
      for (int i = 0; i < 18; i++)
        chk(got0[i] == eb(i, 3, prev18[i] & ~p18[i], p18[i] & ~prev18[i], p18[i]),
            "R3 R5 18-build byte", int'(got0[i]),
            int'(eb(i, 3, prev18[i] & ~p18[i], p18[i] & ~prev18[i], p18[i])));
      for (int i = 0; i < 8; i++)
        chk(got1[i] == eb(i, 4, prev8[i] & ~p8[i], p8[i] & ~prev8[i], p8[i]),
            "R3 R5 8-build byte", int'(got1[i]),
            int'(eb(i, 4, prev8[i] & ~p8[i], p8[i] & ~prev8[i], p8[i])));
      chk(got1[1] == VEC[k][7:0], "R5 probe1 sequence", int'(got1[1]), int'(VEC[k][7:0]));
      prev18 = p18; prev8 = p8;
    end

    // flush to all-low
    p18 = '0; p8 = '0; repeat (5) tick(); poll(8'h92);

    // R4: pulse between polls sets both flags
    p18[5] = 1'b1; p8[3] = 1'b1; repeat (3) tick();
    p18[5] = 1'b0; p8[3] = 1'b0; repeat (4) tick();
    poll(8'h92);
    chk(got0[5] == 8'h2E, "R4 pulse 18-build", int'(got0[5]), 'h2E);
    chk(got1[3] == 8'h36, "R4 pulse 8-build", int'(got1[3]), 'h36);
    chk(got0[4] == 8'h20, "R4 neighbour quiet", int'(got0[4]), 'h20);

    // R7: bad opcode and bad count byte
    n0 = 0; n1 = 0;
    send(8'h55); send(8'h92); repeat (10) tick();
    chk(n0 == 0 && n1 == 0, "R7 wrong opcode", n0 + n1, 0);
    send(8'h19); send(8'h12); send(8'h92); repeat (10) tick();
    chk(n0 == 0 && n1 == 0, "R7 count bit7 clear", n0 + n1, 0);
    poll(8'h92);
    chk(n0 == 18, "R7 recovery", n0, 18);

    // R2: zero, short and oversized counts
    poll(8'h80);
    chk(n0 == 0 && n1 == 0, "R2 zero count", n0 + n1, 0);
    poll(8'h83);
    chk(n0 == 3 && n1 == 3, "R2 count 3", n0 * 16 + n1, 'h33);
    chk(got0[2] == 8'h10 && got1[2] == 8'h20, "R2 order", int'({got0[2], got1[2]}), 'h1020);
    poll(8'hFF);
    chk(n0 == 18 && n1 == 8, "R2 clamp 127", n0 * 256 + n1, 18 * 256 + 8);

    // R11: latency and back-to-back bytes
    n0 = 0; n1 = 0; tx_ready = 1'b1;
    send(8'h19); send(8'h92);
    @(negedge clk);
    chk(!v0 && !v1, "R11 not yet valid", int'({v0, v1}), 0);
    @(negedge clk);
    chk(v0 && d0 == 8'h00, "R11 first byte", int'({v0, d0}), 'h100);
    @(negedge clk);
    chk(v0 && d0 == 8'h08, "R11 second byte", int'({v0, d0}), 'h108);
    tick(); repeat (30) tick();

    // R8: back-pressure
    n0 = 0; n1 = 0; hold_bad = 0; tx_ready = 1'b0;
    query(8'h92); repeat (6) tick();
    chk(v0 && d0 == 8'h00, "R8 held byte", int'({v0, d0}), 'h100);
    for (int s = 0; s < 50; s++) begin tx_ready = s[0]; tick(); end
    tx_ready = 1'b1; repeat (30) tick();
    chk(n0 == 18 && n1 == 8, "R8 all delivered", n0 * 256 + n1, 18 * 256 + 8);
    for (int i = 0; i < 18; i++)
      chk(got0[i] == eb(i, 3, 0, 0, 0), "R8 order under stall", int'(got0[i]), int'(eb(i, 3, 0, 0, 0)));
    chk(hold_bad == 0, "R8 stable while stalled", hold_bad, 0);

    // R9: query during reply dropped
    n0 = 0; n1 = 0; tx_ready = 1'b0;
    query(8'h83); send(8'h19); send(8'h92);
    tx_ready = 1'b1; repeat (30) tick();
    chk(n0 == 3 && n1 == 3, "R9 overlapping query", n0 * 16 + n1, 'h33);

    // R6: edge lands on the capture cycle of probe 1
    n0 = 0; n1 = 0; tx_ready = 1'b0;
    query(8'h92);
    p18[1] = 1'b1; p8[1] = 1'b1;
    tick(); tick();
    tx_ready = 1'b1;
    repeat (30) tick();
    chk(got0[1] == 8'h0B, "R6 collision 18-build", int'(got0[1]), 'h0B);
    chk(got1[1] == 8'h13, "R6 collision 8-build", int'(got1[1]), 'h13);
    poll(8'h92);
    chk(got0[1] == 8'h09, "R6 no repeat 18-build", int'(got0[1]), 'h09);
    chk(got1[1] == 8'h11, "R6 no repeat 8-build", int'(got1[1]), 'h11);

    finish_run();
  end
endmodule